// File: doc/BRIEF.md
# Serial Clock Source Generator

This block produces the basic clock enable that paces a serial channel. The enable is a single-cycle pulse in the system clock domain. The channel has a synchronous shift-clock mode and an asynchronous mode.

In synchronous mode, the shift clock can be driven out or taken in. When it is driven out, the block toggles its own shift clock pin on every baud tick, so the basic clock runs at half the baud tick rate. When it is taken in, the block passes the external pin through a synchroniser and turns the selected edge (rising or falling) into basic clock pulses. Both synchronous variants also give a receive-data sample strobe. That strobe lines up with the edge of the shift clock on which receive data is valid.

In asynchronous mode, a 2-bit selector routes one of four tick sources to the enable: the baud tick, the system clock, a timer tick or an external clock tick. The configuration is captured only while the channel is idle, so a transfer always runs on the settings it started with.

Top module: `shift_clock_source`

## Requirements
- R1: While reset is asserted and in the first cycle after it, basicClkEn and rxSampleStrobe are 0 and shiftClkOut is 1.
- R2: In synchronous mode with extShiftClk=0 and xferActive=1, shiftClkOut inverts at every clock edge where baudTick is 1. basicClkEn is 1 for exactly the cycle after every second tick: the tick that drives shiftClkOut from 0 to 1. The first tick of a transfer drives the pin low.
- R3: In synchronous mode with extShiftClk=0, rxSampleStrobe is 1 in exactly the cycles where basicClkEn is 1, which are the cycles after shiftClkOut rises.
- R4: shiftClkOut is 1 in the cycle after any edge where xferActive is 0. That edge also returns the divider to its idle state. shiftClkOut is constantly 1 in synchronous-input mode and in asynchronous mode.
- R5: In synchronous mode with extShiftClk=1, edgeFall=0 and xferActive=1, a 0-to-1 change of shiftClkIn gives basicClkEn=1 and rxSampleStrobe=1 for one cycle. That cycle follows the third clock edge after the change. Falling changes give nothing.
- R6: With extShiftClk=1 and edgeFall=1, the same applies to 1-to-0 changes of shiftClkIn, and rising changes give nothing.
- R7: In synchronous modes with xferActive=0, baud ticks and shiftClkIn changes give no basicClkEn or rxSampleStrobe pulse.
- R8: In asynchronous mode (modeAsync=1), basicClkEn in each cycle equals the tick selected at the previous edge. The selector values are srcSel 0 for baudTick, 1 for the system clock (always 1), 2 for timerTick and 3 for extClkTick. This holds whatever the level of xferActive. rxSampleStrobe stays 0 in this mode.
- R9: modeAsync, extShiftClk, edgeFall and srcSel are captured only at edges where xferActive is 0. Changes made during a transfer have no effect until xferActive has been 0 at one edge. The new settings then govern the outputs from the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeAsync | input | 1 | 1 = asynchronous mode, 0 = synchronous shift-clock mode |
| extShiftClk | input | 1 | Synchronous mode: 1 = shift clock taken from shiftClkIn, 0 = driven on shiftClkOut |
| edgeFall | input | 1 | External shift clock: 1 = falling edges active, 0 = rising edges active |
| srcSel | input | 2 | Asynchronous source: 0 baud, 1 system clock, 2 timer, 3 external tick |
| xferActive | input | 1 | High while a transfer is in progress |
| baudTick | input | 1 | Single-cycle tick from the baud generator |
| timerTick | input | 1 | Single-cycle tick from an internal timer |
| extClkTick | input | 1 | Single-cycle tick from the external clock input |
| shiftClkIn | input | 1 | External shift clock pin level (asynchronous to clk) |
| basicClkEn | output | 1 | One-cycle basic clock enable |
| rxSampleStrobe | output | 1 | One-cycle receive-data sample strobe (synchronous modes) |
| shiftClkOut | output | 1 | Driven shift clock pin level, idles high |

## Verification
Two things can happen in the same cycle: a request to change the configuration, and a live shift-clock tick inside a transfer. The bench provokes this by switching to asynchronous mode with the system-clock source on the exact cycle of the first baud tick of a synchronous transfer. If the new setting leaked through, basicClkEn would pulse in every cycle. The bench instead expects the halved-baud pattern to continue unchanged. It then expects the outputs to keep the old, gated behaviour for one edge after the transfer ends, and only after that the every-cycle enable of the new source.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

  localparam int NUM_SRC = 4;
  localparam int SRC_W   = $clog2(NUM_SRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_BAUD  = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_TIMER = 2'd2,
    SRC_PIN   = 2'd3
  } srcSel_e;

  // Configuration captured while the channel is idle.
  typedef struct packed {
    logic             asyncMode;
    logic             extShift;
    logic             fallEdge;
    logic [SRC_W-1:0] srcSel;
  } clkCfg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic             divRun;
    logic             divClear;
    logic             extGate;
    logic             fallEdge;
    logic             asyncPick;
    logic [SRC_W-1:0] srcSel;
  } dpCtl_t;

endpackage

// File: rtl/sclk_ctrl.sv
module sclk_ctrl
  import sclk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  clkCfg_t reqCfg,
  input  logic    xferActive,
  output dpCtl_t  ctl
);

  clkCfg_t activeCfg;

  // Settings only move while the channel is idle.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeCfg <= '0;
    end else if (!xferActive) begin
      activeCfg <= reqCfg;
    end
  end

  always_comb begin
    ctl.divRun    = xferActive & ~activeCfg.asyncMode & ~activeCfg.extShift;
    ctl.divClear  = ~ctl.divRun;
    ctl.extGate   = xferActive & ~activeCfg.asyncMode & activeCfg.extShift;
    ctl.fallEdge  = activeCfg.fallEdge;
    ctl.asyncPick = activeCfg.asyncMode;
    ctl.srcSel    = activeCfg.srcSel;
  end

  // R9: configuration frozen during a transfer
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    xferActive |=> $stable(activeCfg))
    else $error("p_cfg_frozen_r9");

endmodule

// File: rtl/sclk_datapath.sv
module sclk_datapath
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  dpCtl_t ctl,
  input  logic   baudTick,
  input  logic   timerTick,
  input  logic   extClkTick,
  input  logic   shiftClkIn,
  output logic   basicClkEn,
  output logic   rxSampleStrobe,
  output logic   shiftClkOut
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  // Pin synchroniser chain
  logic [SYNC_STAGES-1:0] syncChain;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain[0] <= 1'b0;
    else       syncChain[0] <= shiftClkIn;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncChain[g] <= 1'b0;
      else       syncChain[g] <= syncChain[g-1];
    end
  end

  logic syncLvl, prevLvl;
  assign syncLvl = syncChain[LAST_STAGE];

  always_ff @(posedge clk) begin
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncLvl;
  end

  logic riseSeen, fallSeen, extEdge;
  assign riseSeen = syncLvl & ~prevLvl;
  assign fallSeen = ~syncLvl & prevLvl;
  assign extEdge  = ctl.fallEdge ? fallSeen : riseSeen;

  // Asynchronous source mux, index order fixed by the selector encoding
  logic [NUM_SRC-1:0] srcTicks;
  logic               pickedTick;
  assign srcTicks[SRC_BAUD]  = baudTick;
  assign srcTicks[SRC_SYS]   = 1'b1;
  assign srcTicks[SRC_TIMER] = timerTick;
  assign srcTicks[SRC_PIN]   = extClkTick;
  assign pickedTick = srcTicks[ctl.srcSel];

  // Divide-by-two shift clock
  logic divToggle, nextRise, syncPulse;
  assign nextRise  = ctl.divRun & baudTick & ~divToggle;
  assign syncPulse = nextRise | (ctl.extGate & extEdge);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divToggle      <= 1'b1;
      basicClkEn     <= 1'b0;
      rxSampleStrobe <= 1'b0;
    end else begin
      if (ctl.divClear)  divToggle <= 1'b1;
      else if (baudTick) divToggle <= ~divToggle;
      basicClkEn     <= ctl.asyncPick ? pickedTick : syncPulse;
      rxSampleStrobe <= ~ctl.asyncPick & syncPulse;
    end
  end

  assign shiftClkOut = divToggle;

  // R4: pin returns high once the divider is not running
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divClear |=> shiftClkOut)
    else $error("p_idle_high_r4");

  // R2: driven-clock pulses only follow a rising pin edge
  p_rise_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (basicClkEn && $past(ctl.divRun)) |-> (shiftClkOut && !$past(shiftClkOut)))
    else $error("p_rise_pulse_r2");

  // R3: sample strobe never appears without the basic clock
  p_strobe_basic_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxSampleStrobe |-> basicClkEn)
    else $error("p_strobe_basic_r3");

  // R5: external edge pulses are isolated single cycles
  p_ext_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.extGate && basicClkEn) |=> !rxSampleStrobe)
    else $error("p_ext_single_r5");

  // R8: asynchronous mode never strobes receive sampling
  p_async_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.asyncPick |=> !rxSampleStrobe)
    else $error("p_async_quiet_r8");

endmodule

// File: rtl/shift_clock_source.sv
module shift_clock_source
  import sclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeAsync,
  input  logic       extShiftClk,
  input  logic       edgeFall,
  input  logic [1:0] srcSel,
  input  logic       xferActive,
  input  logic       baudTick,
  input  logic       timerTick,
  input  logic       extClkTick,
  input  logic       shiftClkIn,
  output logic       basicClkEn,
  output logic       rxSampleStrobe,
  output logic       shiftClkOut
);

  clkCfg_t reqCfg;
  dpCtl_t  ctl;

  always_comb begin
    reqCfg.asyncMode = modeAsync;
    reqCfg.extShift  = extShiftClk;
    reqCfg.fallEdge  = edgeFall;
    reqCfg.srcSel    = srcSel;
  end

  sclk_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqCfg     (reqCfg),
    .xferActive (xferActive),
    .ctl        (ctl)
  );

  sclk_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .baudTick       (baudTick),
    .timerTick      (timerTick),
    .extClkTick     (extClkTick),
    .shiftClkIn     (shiftClkIn),
    .basicClkEn     (basicClkEn),
    .rxSampleStrobe (rxSampleStrobe),
    .shiftClkOut    (shiftClkOut)
  );

endmodule

// File: tb/sim_shift_clock_source.sv
module sim_shift_clock_source;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeAsync = 1'b0, extShiftClk = 1'b0, edgeFall = 1'b0;
  logic [1:0] srcSel = 2'd0;
  logic xferActive = 1'b0, baudTick = 1'b0, timerTick = 1'b0, extClkTick = 1'b0;
  logic shiftClkIn = 1'b0;
  logic basicClkEn, rxSampleStrobe, shiftClkOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  shift_clock_source u0 (
    .clk(clk), .rstN(rstN), .modeAsync(modeAsync), .extShiftClk(extShiftClk),
    .edgeFall(edgeFall), .srcSel(srcSel), .xferActive(xferActive),
    .baudTick(baudTick), .timerTick(timerTick), .extClkTick(extClkTick),
    .shiftClkIn(shiftClkIn), .basicClkEn(basicClkEn),
    .rxSampleStrobe(rxSampleStrobe), .shiftClkOut(shiftClkOut)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic setCfg(logic am, logic ext, logic fe, logic [1:0] sel);
    xferActive = 1'b0; baudTick = 1'b0; timerTick = 1'b0; extClkTick = 1'b0;
    shiftClkIn = 1'b0;
    modeAsync = am; extShiftClk = ext; edgeFall = fe; srcSel = sel;
    repeat (5) step();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int tc;
    logic h1, h2, h3;
    logic expPulse, expTick;

    // R1: reset state
    repeat (3) step();
    check("R1", "basicClkEn in reset", basicClkEn, 1'b0);
    check("R1", "rxSampleStrobe in reset", rxSampleStrobe, 1'b0);
    check("R1", "shiftClkOut in reset", shiftClkOut, 1'b1);
    rstN = 1'b1;
    step();
    check("R1", "basicClkEn after reset", basicClkEn, 1'b0);
    check("R1", "shiftClkOut after reset", shiftClkOut, 1'b1);

    // R2, R3: driven shift clock, tick spacings 1..4
    for (int k = 1; k <= 4; k++) begin
      setCfg(1'b0, 1'b0, 1'b0, 2'd0);
      xferActive = 1'b1;
      tc = 0;
      for (int c = 0; c < 24; c++) begin
        expTick = (c % k == 0);
        baudTick = expTick;
        step();
        if (expTick) tc++;
        expPulse = expTick && (tc % 2 == 0);
        check("R2", "basicClkEn driven", basicClkEn, expPulse);
        check("R3", "rxSampleStrobe driven", rxSampleStrobe, expPulse);
        check("R2", "shiftClkOut level", shiftClkOut, (tc % 2 == 0));
      end
      // R4: stop mid-period with the pin low
      baudTick = 1'b1; step(); tc++;
      check("R2", "pin low before idle", shiftClkOut, (tc % 2 == 0));
      baudTick = 1'b0; xferActive = 1'b0;
      step();
      check("R4", "shiftClkOut idle high", shiftClkOut, 1'b1);
      xferActive = 1'b1; baudTick = 1'b1;
      step();
      check("R4", "divider restarts low", shiftClkOut, 1'b0);
      check("R2", "no pulse on first tick", basicClkEn, 1'b0);
      baudTick = 1'b0; xferActive = 1'b0;
      step();
    end

    // R5, R6: external shift clock, both edge selections, several rates
    for (int fe = 0; fe < 2; fe++) begin
      for (int k = 1; k <= 4; k++) begin
        setCfg(1'b0, 1'b1, fe[0], 2'd0);
        xferActive = 1'b1;
        h1 = 1'b0; h2 = 1'b0; h3 = 1'b0;
        for (int c = 0; c < 32; c++) begin
          shiftClkIn = ((c / k) % 2 == 1);
          step();
          // output after edge c reflects pin values driven before edges c-2 and c-3
          expPulse = fe[0] ? (!h2 && h3) : (h2 && !h3);
          check(fe[0] ? "R6" : "R5", "basicClkEn ext edge", basicClkEn, expPulse);
          check(fe[0] ? "R6" : "R5", "rxSampleStrobe ext edge", rxSampleStrobe, expPulse);
          check("R4", "shiftClkOut high in input mode", shiftClkOut, 1'b1);
          h3 = h2; h2 = h1; h1 = shiftClkIn;
        end
        xferActive = 1'b0;
        step();
      end
    end

    // R7: synchronous modes idle
    setCfg(1'b0, 1'b1, 1'b0, 2'd0);
    for (int c = 0; c < 16; c++) begin
      shiftClkIn = ((c / 2) % 2 == 1);
      step();
      check("R7", "no pulse idle ext", basicClkEn, 1'b0);
      check("R7", "no strobe idle ext", rxSampleStrobe, 1'b0);
    end
    setCfg(1'b0, 1'b0, 1'b0, 2'd0);
    for (int c = 0; c < 8; c++) begin
      baudTick = 1'b1;
      step();
      check("R7", "no pulse idle driven", basicClkEn, 1'b0);
      check("R4", "pin high idle driven", shiftClkOut, 1'b1);
    end
    baudTick = 1'b0;

    // R8: asynchronous source selection
    for (int s = 0; s < 4; s++) begin
      setCfg(1'b1, 1'b0, 1'b0, s[1:0]);
      for (int c = 0; c < 30; c++) begin
        baudTick   = (c % 2 == 0);
        timerTick  = (c % 3 == 0);
        extClkTick = (c % 5 == 1);
        xferActive = (c % 7 < 3);
        case (s)
          0: expTick = baudTick;
          1: expTick = 1'b1;
          2: expTick = timerTick;
          default: expTick = extClkTick;
        endcase
        step();
        check("R8", "basicClkEn async source", basicClkEn, expTick);
        check("R8", "rxSampleStrobe async", rxSampleStrobe, 1'b0);
        check("R4", "shiftClkOut async", shiftClkOut, 1'b1);
      end
    end

    // R9: configuration change arriving with a live tick
    setCfg(1'b0, 1'b0, 1'b0, 2'd0);
    xferActive = 1'b1;
    modeAsync = 1'b1; srcSel = 2'd1; edgeFall = 1'b1;
    tc = 0;
    for (int c = 0; c < 10; c++) begin
      expTick = (c % 2 == 0);
      baudTick = expTick;
      step();
      if (expTick) tc++;
      expPulse = expTick && (tc % 2 == 0);
      check("R9", "old config kept basicClkEn", basicClkEn, expPulse);
      check("R9", "old config kept shiftClkOut", shiftClkOut, (tc % 2 == 0));
    end
    baudTick = 1'b0; xferActive = 1'b0;
    step();
    check("R9", "capture edge still old mode", basicClkEn, 1'b0);
    check("R4", "pin high at end", shiftClkOut, 1'b1);
    step();
    check("R9", "new system-clock source active", basicClkEn, 1'b1);
    check("R9", "new mode no strobe", rxSampleStrobe, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule